// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the front end of a configuration space. It is reached through two adjacent byte addresses. A byte written to the lower address picks a configuration register. A read or write at the upper address then reaches the register that was picked.

The port is sealed after reset. It only opens when a fixed key byte arrives at the index address twice in a row. A separate closing key seals it again. While the port is sealed, register writes are dropped and every read returns all ones.

Once the port is open, a selector register decides which logical device's bank answers the device-specific index. The identification bytes answer the same way whichever device is selected. Each logical device owns one enable bit, and that bit is driven out of the block. A strap input chooses which of two base addresses the port answers at.

Top module: `cfgp_port`

## Requirements
- R1: After reset the port is sealed, every `dev_enable` bit is 0, the selector and index hold 0, and any read at either port address while sealed returns 0xFF.
- R2: The port opens only after two consecutive index-address writes of 0x87. Once open, a read of the index address returns the current index, which is still 0x00 after the first opening from reset.
- R3: While sealed, an index-address write of any byte other than 0x87 restarts the key sequence. Data-address writes neither advance nor restart the sequence.
- R4: An index-address write of 0xAA seals an open port. The 0xAA is not stored as an index, so index 0xAA cannot be selected. While sealed, data writes change nothing. After reopening, the index, the selector and the enables hold the values they had before sealing.
- R5: Identification bytes: index 0x20 returns the device-ID high byte and 0x21 its low byte; 0x22 returns the revision; 0x23 returns 0x19 and 0x24 returns 0x34 (vendor ID 0x1934, high byte first). With the defaults the device ID is 0x5A17 and the revision is 0x03.
- R6: Index 0x07 is the logical-device selector. It stores and reads back a full byte.
- R7: Index 0x30 reaches bit 0 of the selected device's enable. A write stores data bit 0 into `dev_enable[selector]`, and a read returns 0000000e. When the selector is NUM_DEV or above, writes are dropped and reads return 0x00. One write changes at most one enable bit.
- R8: Every index that is not listed in R5 to R7 reads 0x00 and ignores writes.
- R9: With `base_alt`=0 the port sits at 0x2E (index) and 0x2F (data). With `base_alt`=1 it sits at 0x4E and 0x4F. Accesses at any other address have no effect.
- R10: Read data is registered. `bus_rdata` takes its new value at the clock edge that samples `bus_rd`, and it holds that value until the next read that hits the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_alt | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |

## Verification
Every write takes effect at the clock edge that samples its strobe. The key state, index, selector and enables all change at that edge, so `dev_enable` is compared at the falling edge that follows. A read returns its byte one edge after the strobe. The bench therefore holds a strobe for exactly one rising edge and samples `bus_rdata` at the falling edge that follows it. That falling edge comes before any later stimulus, so each value seen belongs to exactly one access.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam logic [7:0] KEY_OPEN     = 8'h87;
  localparam logic [7:0] KEY_SHUT     = 8'hAA;
  localparam logic [7:0] RD_SEALED    = 8'hFF;
  localparam logic [7:0] IDX_SEL      = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_VEND_HI  = 8'h23;
  localparam logic [7:0] IDX_VEND_LO  = 8'h24;
  localparam logic [7:0] IDX_ENABLE   = 8'h30;

  typedef enum logic [1:0] {KS_SHUT, KS_HALF, KS_OPEN} key_state_e;

  // Index-port address chosen by the strap; the data port is one above.
  function automatic logic [15:0] port_base(input logic alt);
    return alt ? 16'h004E : 16'h002E;
  endfunction

  // Next key state for an index-address write of byte b.
  function automatic key_state_e key_next(input key_state_e s, input logic [7:0] b);
    case (s)
      KS_SHUT: return (b == KEY_OPEN) ? KS_HALF : KS_SHUT;
      KS_HALF: return (b == KEY_OPEN) ? KS_OPEN : KS_SHUT;
      default: return (b == KEY_SHUT) ? KS_SHUT : KS_OPEN;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_keyctl.sv
`timescale 1ns/1ps
module cfgp_keyctl
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       port_open,
  output logic [7:0] index
);
  key_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= KS_SHUT;
      index <= 8'h00;
    end else if (idx_wr) begin
      state <= key_next(state, wdata);
      if (state == KS_OPEN && wdata != KEY_SHUT)
        index <= wdata;
    end
  end

  assign port_open = (state == KS_OPEN);

  assert_open_needs_two_keys_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_open) |-> ($past(idx_wr) && $past(wdata) == KEY_OPEN && $past(state) == KS_HALF));

  assert_stray_byte_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_open && idx_wr && wdata != KEY_OPEN) |=> (state == KS_SHUT));

  assert_shut_key_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_open && idx_wr && wdata == KEY_SHUT) |=> (!port_open && $stable(index)));
endmodule

// File: rtl/cfgp_bank.sv
`timescale 1ns/1ps
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] DEV_ID  = 16'h5A17,
  parameter logic [7:0]  DEV_REV = 8'h03,
  parameter logic [15:0] VEND_ID = 16'h1934
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dat_wr,
  input  logic [7:0]         index,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_byte,
  output logic [NUM_DEV-1:0] dev_enable
);
  logic [7:0]         sel_q;
  logic [NUM_DEV-1:0] en_q;
  logic               sel_en;

  always_ff @(posedge clk) begin
    if (!rst_n)                             sel_q <= 8'h00;
    else if (dat_wr && index == IDX_SEL)    sel_q <= wdata;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_q[g] <= 1'b0;
      else if (dat_wr && index == IDX_ENABLE && sel_q == 8'(g))
        en_q[g] <= wdata[0];
    end
  end

  always_comb begin
    sel_en = 1'b0;
    for (int d = 0; d < NUM_DEV; d++)
      if (sel_q == 8'(d)) sel_en = en_q[d];
  end

  always_comb begin
    case (index)
      IDX_SEL:      rd_byte = sel_q;
      IDX_DEVID_HI: rd_byte = DEV_ID[15:8];
      IDX_DEVID_LO: rd_byte = DEV_ID[7:0];
      IDX_REV:      rd_byte = DEV_REV;
      IDX_VEND_HI:  rd_byte = VEND_ID[15:8];
      IDX_VEND_LO:  rd_byte = VEND_ID[7:0];
      IDX_ENABLE:   rd_byte = {7'b0, sel_en};
      default:      rd_byte = 8'h00;
    endcase
  end

  assign dev_enable = en_q;

  assert_enable_single_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dev_enable ^ $past(dev_enable)) <= 1);

  assert_enable_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(dev_enable));

  assert_selector_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(sel_q));
endmodule

// File: rtl/cfgp_port.sv
`timescale 1ns/1ps
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] DEV_ID  = 16'h5A17,
  parameter logic [7:0]  DEV_REV = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_alt,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NUM_DEV-1:0] dev_enable
);
  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              hit_idx, hit_dat, idx_wr, dat_wr, rd_hit;
  logic              port_open;
  logic [7:0]        index, bank_byte;

  assign idx_addr = ADDR_W'(port_base(base_alt));
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign hit_idx  = (bus_addr == idx_addr);
  assign hit_dat  = (bus_addr == dat_addr);
  assign idx_wr   = bus_wr && hit_idx;
  assign dat_wr   = bus_wr && hit_dat && port_open;
  assign rd_hit   = bus_rd && (hit_idx || hit_dat);

  cfgp_keyctl u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
    .port_open(port_open), .index(index)
  );

  cfgp_bank #(.NUM_DEV(NUM_DEV), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_bank (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .index(index), .wdata(bus_wdata),
    .rd_byte(bank_byte), .dev_enable(dev_enable)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= RD_SEALED;
    else if (rd_hit) begin
      if (!port_open)   bus_rdata <= RD_SEALED;
      else if (hit_idx) bus_rdata <= index;
      else              bus_rdata <= bank_byte;
    end
  end

  assert_sealed_read_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !port_open) |=> (bus_rdata == RD_SEALED));

  assert_sealed_write_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open |=> $stable(dev_enable));

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(bus_rdata));
endmodule

// File: tb/sim_cfgp_port.sv
`timescale 1ns/1ps
module sim_cfgp_port;
  localparam int ND = 4;
  logic clk = 1'b0, rst_n = 1'b0, base_alt = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h0, bus_rdata;
  logic [ND-1:0] dev_enable;
  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [ND-1:0] m_en = '0;
  logic [7:0] m_sel = 8'h00;

  always #10 clk = ~clk;

  cfgp_port u0 (.clk(clk), .rst_n(rst_n), .base_alt(base_alt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_enable(dev_enable));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  // Expected register byte, restated from R5..R8.
  function automatic logic [7:0] model(input logic [7:0] i);
    if (i == 8'h07) return m_sel;
    if (i == 8'h20) return 8'h5A;
    if (i == 8'h21) return 8'h17;
    if (i == 8'h22) return 8'h03;
    if (i == 8'h23) return 8'h19;
    if (i == 8'h24) return 8'h34;
    if (i == 8'h30) return (m_sel < ND) ? {7'b0, m_en[m_sel[1:0]]} : 8'h00;
    return 8'h00;
  endfunction

  initial begin
    #3000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 enables", 8'(dev_enable), 8'h00);
    rd(16'h2F, v); chk("R1 sealed data read", v, 8'hFF);
    rd(16'h2E, v); chk("R1 sealed index read", v, 8'hFF);
    // R3: stray byte restarts; data writes do not count
    wr(16'h2E, 8'h87); wr(16'h2F, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'h87);
    rd(16'h2F, v); chk("R3 stray byte keeps sealed", v, 8'hFF);
    chk("R3 sealed data write inert", 8'(dev_enable), 8'h00);
    // completing the pair with the pending 0x87 above, separated only by a data write
    wr(16'h2F, 8'h22); wr(16'h2E, 8'h87);
    // R2: open, index still 0
    rd(16'h2E, v); chk("R2 open index read", v, 8'h00);
    // R5 R6 R7 R8: sweep of all selectable indices, selector 0
    for (int i = 0; i < 256; i++) begin
      if (i == 8'hAA) continue;
      wr(16'h2E, 8'(i)); rd(16'h2F, v); chk("R5-R8 sweep sel0", v, model(8'(i)));
    end
    // R7 R6: enable per device including out-of-range selectors
    for (int d = 0; d < ND + 2; d++) begin
      wr(16'h2E, 8'h07); wr(16'h2F, 8'(d)); m_sel = 8'(d);
      rd(16'h2F, v); chk("R6 selector readback", v, 8'(d));
      wr(16'h2E, 8'h30); wr(16'h2F, (d % 2 == 0) ? 8'hFF : 8'h01);
      if (d < ND) m_en[d] = 1'b1;
      chk("R7 enable out", 8'(dev_enable), 8'(m_en));
      rd(16'h2F, v); chk("R7 enable readback", v, model(8'h30));
    end
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h02); m_sel = 8'h02;
    wr(16'h2E, 8'h30); wr(16'h2F, 8'hFE); m_en[2] = 1'b0;
    chk("R7 clear one enable", 8'(dev_enable), 8'(m_en));
    rd(16'h2F, v); chk("R7 cleared readback", v, 8'h00);
    // R8: unimplemented index ignores writes
    wr(16'h2E, 8'h31); wr(16'h2F, 8'h5C); rd(16'h2F, v); chk("R8 write ignored", v, 8'h00);
    // R4: seal, writes inert, state preserved
    wr(16'h2E, 8'h30); wr(16'h2E, 8'hAA);
    rd(16'h2F, v); chk("R4 sealed read", v, 8'hFF);
    wr(16'h2F, 8'h01);
    chk("R4 sealed write inert", 8'(dev_enable), 8'(m_en));
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
    rd(16'h2E, v); chk("R4 index kept", v, 8'h30);
    rd(16'h2F, v); chk("R4 enable kept", v, model(8'h30));
    wr(16'h2E, 8'h07); rd(16'h2F, v); chk("R4 selector kept", v, 8'h02);
    // R9: alternate base
    base_alt = 1'b1;
    wr(16'h2E, 8'h30); wr(16'h2F, 8'h00);
    chk("R9 old base ignored", 8'(dev_enable), 8'(m_en));
    rd(16'h4E, v); chk("R9 alt index read", v, 8'h07);
    wr(16'h4E, 8'h24); rd(16'h4F, v); chk("R9 alt data read", v, 8'h34);
    // R10: rdata holds through non-hit reads and writes
    rd(16'h1234, v); chk("R10 hold on miss", v, 8'h34);
    wr(16'h4E, 8'h20); chk("R10 hold on write", bus_rdata, 8'h34);
    rd(16'h4F, v); chk("R10 new read", v, 8'h5A);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule